// File: doc/BRIEF.md
# Seven-Operand Carry-Save Tree Adder

This block adds seven unsigned operands of equal width that are not shifted relative to each other. Each reduction level is a row of 3:2 full adders. Every row turns three vectors into a sum vector and a carry vector, and the carry vector is weighted one bit higher. Vectors that do not fit into a group of three pass on unchanged. Four levels reduce the seven vectors to two (7 → 5 → 4 → 3 → 2). One carry-propagate adder then merges the two vectors into the final sum. That merge is the only place where carries ripple across columns.

Operand sets enter through a valid/ready stream and results leave through another. When a transfer is refused, the whole datapath freezes. A set is taken when `in_valid` and `in_ready` are both high at a rising clock edge. A result is handed over when `out_valid` and `out_ready` are both high. A result that is on offer stays on offer, unchanged, until it is taken. While a result is blocked, `in_ready` is low, so no set is lost.

The parameter `PIPE` chooses the timing. With `PIPE=1` there is a register after each carry-save level and after the merge. With `PIPE=0` there is only the output register.

Top module: `csa7_tree_add`

## Requirements
- R1: `out_sum` equals the exact unsigned sum of the seven operands, with `W+3` bits and no truncation. When every operand is all ones, the result is 7·(2^W−1).
- R2: With `PIPE=1` and `out_ready` held high, a set taken at one rising edge produces `out_valid` with its sum 5 rising edges later. With `PIPE=0` the delay is 1 edge.
- R3: Each accepted set produces exactly one result, in the order the sets were taken. `out_valid` is never high when no result is owed.
- R4: While `out_valid` is high and `out_ready` is low, `in_ready` is low. At the next edge, `out_valid` stays high and `out_sum` keeps its value.
- R5: Whenever `out_valid` is low or `out_ready` is high, `in_ready` is high. With `out_ready` held high, one set can be taken on every cycle.
- R6: After `rst_n` is released, `out_valid` is low and `in_ready` is high.
- R7: Operand i (i = 0..6) occupies bits `[i*W +: W]` of `in_ops`. Each position adds with weight one, so a set with a single non-zero operand returns that operand's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operand set is offered |
| in_ready | output | 1 | The block takes the offered set at this edge |
| in_ops | input | 7*W | Seven packed unsigned operands; operand i is in bits [i*W +: W] |
| out_valid | output | 1 | A result is on offer |
| out_ready | input | 1 | The consumer takes the result |
| out_sum | output | W+3 | Sum of the seven operands |

## Verification
All-zero and all-ones sets cover the two extremes. The all-ones case needs every one of the three growth bits and would show a carry dropped at any level. A single non-zero operand in each of the seven positions shows that every input reaches the tree with weight one and sits in the right slice. Random back-to-back sets with `out_ready` held high check latency and full throughput. A phase with random `out_ready` shows whether a stall holds the offered result and keeps the order of sets in flight.

// File: rtl/csa7_pkg.sv
package csa7_pkg;
  localparam int N_OPS  = 7;  // operands summed per set
  localparam int N_LVL  = 4;  // carry-save levels from 7 vectors to 2
  localparam int GROWTH = 3;  // extra result bits: 7*(2^W-1) < 2^(W+3)
endpackage

// File: rtl/csa7_row.sv
// One 3:2 reduction row: a full adder per column, carries moved up by one.
module csa7_row #(
  parameter int DW = 11
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic [DW-1:0] z,
  output logic [DW-1:0] s,
  output logic [DW-1:0] c
);
  logic [DW-1:0] maj;

  for (genvar b = 0; b < DW; b++) begin : g_fa
    assign s[b]   = x[b] ^ y[b] ^ z[b];
    assign maj[b] = (x[b] & y[b]) | (x[b] & z[b]) | (y[b] & z[b]);
  end

  // the lowest column receives a zero so columns stay aligned
  assign c = {maj[DW-2:0], 1'b0};
endmodule

// File: rtl/csa7_stage.sv
// Optional register slice carrying a valid bit; freezes when en is low.
module csa7_stage #(
  parameter int DW  = 8,
  parameter bit REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          vi,
  input  logic [DW-1:0] di,
  output logic          vo,
  output logic [DW-1:0] dout
);
  if (REG) begin : g_reg
    logic          v_q;
    logic [DW-1:0] d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (en) begin
        v_q <= vi;
        if (vi) d_q <= di;
      end
    end
    assign vo   = v_q;
    assign dout = d_q;
  end else begin : g_wire
    assign vo   = vi;
    assign dout = di;
  end
endmodule

// File: rtl/csa7_merge.sv
// Final carry-propagate adder joining the sum and carry vectors.
module csa7_merge #(
  parameter int DW = 11
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum
);
  assign sum = a + b;
endmodule

// File: rtl/csa7_tree_add.sv
module csa7_tree_add
  import csa7_pkg::*;
#(
  parameter int W    = 8,
  parameter bit PIPE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [N_OPS*W-1:0] in_ops,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [W+GROWTH-1:0] out_sum
);
  localparam int OW = W + GROWTH;

  logic en;
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  // operand unpack, zero-extended to the result width
  logic [N_OPS-1:0][OW-1:0] op;
  for (genvar i = 0; i < N_OPS; i++) begin : g_op
    assign op[i] = {{GROWTH{1'b0}}, in_ops[i*W +: W]};
  end

  // level 1: 7 -> 5
  logic [OW-1:0] s1a, c1a, s1b, c1b;
  logic [4:0][OW-1:0] d1, q1;
  logic v1;
  csa7_row #(.DW(OW)) u_r1a (.x(op[0]), .y(op[1]), .z(op[2]), .s(s1a), .c(c1a));
  csa7_row #(.DW(OW)) u_r1b (.x(op[3]), .y(op[4]), .z(op[5]), .s(s1b), .c(c1b));
  assign d1 = {op[6], c1b, s1b, c1a, s1a};
  csa7_stage #(.DW(5*OW), .REG(PIPE)) u_st1 (
    .clk(clk), .rst_n(rst_n), .en(en), .vi(in_valid), .di(d1), .vo(v1), .dout(q1));

  // level 2: 5 -> 4
  logic [OW-1:0] s2, c2;
  logic [3:0][OW-1:0] d2, q2;
  logic v2;
  csa7_row #(.DW(OW)) u_r2 (.x(q1[0]), .y(q1[1]), .z(q1[2]), .s(s2), .c(c2));
  assign d2 = {q1[4], q1[3], c2, s2};
  csa7_stage #(.DW(4*OW), .REG(PIPE)) u_st2 (
    .clk(clk), .rst_n(rst_n), .en(en), .vi(v1), .di(d2), .vo(v2), .dout(q2));

  // level 3: 4 -> 3
  logic [OW-1:0] s3, c3;
  logic [2:0][OW-1:0] d3, q3;
  logic v3;
  csa7_row #(.DW(OW)) u_r3 (.x(q2[0]), .y(q2[1]), .z(q2[2]), .s(s3), .c(c3));
  assign d3 = {q2[3], c3, s3};
  csa7_stage #(.DW(3*OW), .REG(PIPE)) u_st3 (
    .clk(clk), .rst_n(rst_n), .en(en), .vi(v2), .di(d3), .vo(v3), .dout(q3));

  // level 4: 3 -> 2
  logic [OW-1:0] s4, c4;
  logic [1:0][OW-1:0] d4, q4;
  logic v4;
  csa7_row #(.DW(OW)) u_r4 (.x(q3[0]), .y(q3[1]), .z(q3[2]), .s(s4), .c(c4));
  assign d4 = {c4, s4};
  csa7_stage #(.DW(2*OW), .REG(PIPE)) u_st4 (
    .clk(clk), .rst_n(rst_n), .en(en), .vi(v3), .di(d4), .vo(v4), .dout(q4));

  // merge and output register
  logic [OW-1:0] merged;
  csa7_merge #(.DW(OW)) u_merge (.a(q4[0]), .b(q4[1]), .sum(merged));
  csa7_stage #(.DW(OW), .REG(1'b1)) u_out (
    .clk(clk), .rst_n(rst_n), .en(en), .vi(v4), .di(merged), .vo(out_valid), .dout(out_sum));
endmodule

// File: rtl/csa7_chk.sv
module csa7_chk
  import csa7_pkg::*;
#(
  parameter int W    = 8,
  parameter bit PIPE = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [N_OPS*W-1:0] in_ops,
  input logic               out_valid,
  input logic               out_ready,
  input logic [W+GROWTH-1:0] out_sum
);
  localparam int OW  = W + GROWTH;
  localparam int LAT = PIPE ? N_LVL + 1 : 1;
  localparam logic [OW:0] MAXS = (OW + 1)'(N_OPS) * (OW + 1)'((1 << W) - 1);

  // sets accepted but not yet delivered
  logic [7:0] owed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed <= '0;
    else owed <= owed + 8'(in_valid && in_ready) - 8'(out_valid && out_ready);
  end

  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_sum} <= MAXS));

  a_r3_owed_only: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (owed != 8'd0));

  a_r3_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= 8'(LAT));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  a_r4_block_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r5_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);
endmodule

bind csa7_tree_add csa7_chk #(.W(W), .PIPE(PIPE)) u_chk (.*);

// File: tb/sim_csa7_tree_add.sv
`timescale 1ns/1ps
module sim_csa7_tree_add;
  localparam int W   = 8;
  localparam int OW  = W + 3;
  localparam int LAT = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [7*W-1:0]  in_ops = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [OW-1:0]   out_sum;

  always #2.5 clk = ~clk;

  csa7_tree_add #(.W(W), .PIPE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ops(in_ops), .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum));

  int tests = 0, fails = 0;
  int cyc = 0;
  bit bp_on = 1'b0, stalled_seen = 1'b0, done = 1'b0;
  bit prev_stall = 1'b0;
  logic [OW-1:0] prev_sum = '0;
  int exp_q[$];
  int acc_q[$];
  string tag_q[$];
  string cur_tag = "R1";

  function automatic int ref_sum(logic [7*W-1:0] v);
    int s = 0;
    for (int i = 0; i < 7; i++) s += int'(v[i*W +: W]);
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // out_ready driver
  always @(posedge clk) begin
    #1 out_ready = bp_on ? 1'($urandom % 2) : 1'b1;
  end

  // monitor: values are stable between posedge+1 and the next posedge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_stall) begin
        check("R4 valid held", int'(out_valid), 1);
        check("R4 sum held", int'(out_sum), int'(prev_sum));
      end
      if (out_valid && !out_ready) begin
        stalled_seen = 1'b1;
        check("R4 in_ready low", int'(in_ready), 0);
      end else begin
        check("R5 in_ready high", int'(in_ready), 1);
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_sum(in_ops));
        acc_q.push_back(cyc);
        tag_q.push_back(cur_tag);
      end
      if (out_valid && exp_q.size() == 0) begin
        check("R3 phantom result", 1, 0);
      end else if (out_valid && out_ready) begin
        int e, a;
        string t;
        e = exp_q.pop_front();
        a = acc_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(out_sum), e);
        if (!stalled_seen) check("R2 latency", cyc - a, LAT);
      end
      prev_stall = out_valid && !out_ready;
      prev_sum   = out_sum;
    end
  end

  task automatic send(logic [7*W-1:0] v);
    bit got;
    got = 1'b0;
    while (!got) begin
      @(posedge clk);
      #1;
      in_valid = 1'b1;
      in_ops   = v;
      @(negedge clk);
      got = in_ready;
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_b2b(int n, int gap_pct);
    for (int k = 0; k < n; k++) begin
      logic [7*W-1:0] v;
      for (int i = 0; i < 7; i++) v[i*W +: W] = W'($urandom);
      in_valid = 1'b1;
      in_ops = v;
      do @(negedge clk); while (!in_ready);
      @(posedge clk);
      #1;
      if (($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;
        @(posedge clk);
        #1;
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R6 out_valid after reset", int'(out_valid), 0);
    check("R6 in_ready after reset", int'(in_ready), 1);

    cur_tag = "R1 zeros";
    send('0);
    cur_tag = "R1 all ones";
    send('1);
    send('1);
    cur_tag = "R7 single operand";
    for (int i = 0; i < 7; i++) begin
      logic [7*W-1:0] v = '0;
      v[i*W +: W] = W'(8'hA5 ^ (i * 17));
      send(v);
    end
    cur_tag = "R1 one-hot columns";
    for (int b = 0; b < W; b++) begin
      logic [7*W-1:0] v = '0;
      for (int i = 0; i < 7; i++) v[i*W + b] = 1'b1;
      send(v);
    end
    repeat (8) @(posedge clk);
    #1;

    cur_tag = "R5 back-to-back";
    send_b2b(40, 0);
    cur_tag = "R1 random gaps";
    send_b2b(30, 40);
    repeat (8) @(posedge clk);
    #1;

    bp_on = 1'b1;
    cur_tag = "R3 order under stall";
    send_b2b(60, 20);
    cur_tag = "R4 all ones under stall";
    for (int k = 0; k < 6; k++) send('1);
    repeat (4) @(posedge clk);
    bp_on = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R3 all results delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule